// File: doc/BRIEF.md
# Functional Unit Reservation Scoreboard

This block sits at the issue stage of a small core that has seven execution resources: two integer ALUs, a floating-point adder, a floating-point multiplier, a floating-point divider, a square-root unit and a load/store unit. Each cycle the front end offers one decoded operation as a 4-bit class code and a mode flag. The block decides whether that operation can issue now, reserves the unit or units it needs, and counts down how long each reservation lasts. It also raises a one-cycle flag on the cycle in which each result becomes usable. It does no arithmetic, no memory access and no register dependency tracking.

An operation issues in the cycle where `iss_valid` and `iss_ready` are both high. That cycle is the issue cycle t. An operation with latency L raises its unit's bit of `res_rdy` for exactly one cycle, cycle t+L. The grant and result vectors use this bit order: 0 ALU1, 1 ALU2, 2 FP adder, 3 FP multiplier, 4 FP divider, 5 square-root unit, 6 load/store unit. The flag `iss_dbl` selects the 64-bit or double-precision form of an operation. For conversions it instead selects the integer-to-single form.

Each unit can deliver only one result per cycle. An operation whose result would land in the same cycle as an earlier result from the same unit waits until it no longer collides.

Top module: `resv_board`

## Requirements
- R1: Class 0 (plain integer ALU work) goes to ALU1 (grant bit 0) when ALU1 can accept it. Otherwise it goes to ALU2 (grant bit 1). Its latency is 1.
- R2: Classes 1 (shift, branch, jump, call, integer conditional move) and 2 (move to the FP register file) are granted only ALU1. They have latency 1 and 3 respectively.
- R3: Class 3 (move from the FP register file) uses the FP multiplier (bit 3) with latency 2. Class 4 (integer multiply) is granted only ALU2, which it holds for 6 cycles (iss_dbl=0) or 10 cycles (iss_dbl=1). Its result arrives at the same latency.
- R4: Class 5 (integer divide) is granted only ALU2, which it holds for 35 or 67 cycles. Its LO result sets res_rdy bit 1 at latency 34 or 66. `hi_rdy` follows exactly one cycle later.
- R5: Classes 6 (integer load, latency 2), 7 (FP load, latency 3) and 8 (store, no result) each take the load/store unit (bit 6) for one cycle.
- R6: Class 12 (fused multiply-add) is granted the adder and multiplier together (grant 0x0C). It occupies the adder in cycle t and the multiplier in cycle t+1. Its result appears on bit 3 at latency 4, and `fma_fwd` pulses at latency 2.
- R7: Class 9 (FP add) uses the adder and class 10 (FP multiply) uses the multiplier, each for one cycle with latency 2. Class 11 (conversion) uses the adder: with iss_dbl=1 it holds it 2 cycles with latency 4, otherwise 1 cycle with latency 2.
- R8: Class 13 (FP divide) holds the divider (bit 4) for 14 or 21 cycles, with latency 12 or 19. Class 14 (square root) holds its unit (bit 5) for 20 or 35 cycles, with latency 18 or 33. Neither unit blocks the other or the multiplier.
- R9: Class 15 (unknown) issues only when both ALUs are free. It is granted both (0x03) and reports its result on bit 0 at latency 1.
- R10: While a needed unit is still held, `iss_ready` is low and `grant` is zero. The operation issues in the first cycle in which its units are free again.
- R11: An operation whose result would coincide with an earlier result from the same unit is held until the results no longer coincide.
- R12: After synchronous reset every unit is idle: all outputs are zero and any class can issue at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is offered this cycle |
| iss_ready | output | 1 | The offered class can issue this cycle |
| iss_cls | input | 4 | Operation class code |
| iss_dbl | input | 1 | Double/64-bit form; for conversions, integer-to-single |
| grant | output | 7 | Units reserved by the operation issuing this cycle |
| res_rdy | output | 7 | Per-unit result-available pulse |
| hi_rdy | output | 1 | HI half of an integer divide is available |
| fma_fwd | output | 1 | Fused multiply-add result can be forwarded to another multiply-add |

## Verification
The assertions assume that the class and mode inputs stay stable from the first offer of an operation until it issues. The hold-countdown and slot checks assume that the decode never loads a unit that is still held. The stimulus keeps the offer stable because the driver keeps the same class on the inputs until it sees `iss_ready` high. Back-to-back sequences are arranged so that each stall comes only from a hold or a result collision. This lets the expected stall count be worked out from the hold and latency figures alone.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int NUM_UNITS = 7;
    localparam int CNT_W     = 7;   // covers the 67-cycle divide hold
    localparam int PIPE_D    = 4;   // short-latency result slots per unit

    localparam int U_ALU1 = 0;
    localparam int U_ALU2 = 1;
    localparam int U_FADD = 2;
    localparam int U_FMUL = 3;
    localparam int U_FDIV = 4;
    localparam int U_FSQR = 5;
    localparam int U_LSU  = 6;

    typedef enum logic [3:0] {
        OP_IALU  = 4'd0,
        OP_ALU1  = 4'd1,
        OP_MTF   = 4'd2,
        OP_MFF   = 4'd3,
        OP_IMUL  = 4'd4,
        OP_IDIV  = 4'd5,
        OP_LD    = 4'd6,
        OP_FLD   = 4'd7,
        OP_ST    = 4'd8,
        OP_FADD  = 4'd9,
        OP_FMUL  = 4'd10,
        OP_FCVT  = 4'd11,
        OP_FMA   = 4'd12,
        OP_FDIV  = 4'd13,
        OP_FSQRT = 4'd14,
        OP_UNK   = 4'd15
    } op_cls_e;

    localparam int HOLD_IMUL_S = 6;
    localparam int HOLD_IMUL_D = 10;
    localparam int HOLD_IDIV_S = 35;
    localparam int HOLD_IDIV_D = 67;
    localparam int HOLD_FDIV_S = 14;
    localparam int HOLD_FDIV_D = 21;
    localparam int HOLD_SQRT_S = 20;
    localparam int HOLD_SQRT_D = 35;

    localparam int LAT_IDIV_S  = HOLD_IDIV_S - 1;
    localparam int LAT_IDIV_D  = HOLD_IDIV_D - 1;
    localparam int LAT_FDIV_S  = 12;
    localparam int LAT_FDIV_D  = 19;
    localparam int LAT_SQRT_S  = 18;
    localparam int LAT_SQRT_D  = 33;
    localparam int LAT_FMA     = 4;
    localparam int LAT_FMA_FWD = 2;

endpackage

// File: rtl/resv_unit.sv
module resv_unit
    import resv_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PD = PIPE_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [CW-1:0] hold_m1,
    input  logic [CW-1:0] lat,
    input  logic          hi_mark,
    output logic [CW-1:0] busy_q,
    output logic [PD-1:0] pend_q,
    output logic          res,
    output logic          hi_res
);

    typedef struct packed {
        logic [CW-1:0] busy;
        logic [PD-1:0] pend;
        logic [CW-1:0] lcnt;
        logic          hi_m;
        logic          hi_p;
    } ustate_t;

    ustate_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = (st_q.busy != '0) ? st_q.busy - 1'b1 : '0;
        st_d.pend = st_q.pend >> 1;
        st_d.lcnt = (st_q.lcnt != '0) ? st_q.lcnt - 1'b1 : '0;
        st_d.hi_p = (st_q.lcnt == CW'(1)) && st_q.hi_m;
        if (ld) begin
            st_d.busy = hold_m1;
            for (int i = 0; i < PD; i++) begin
                if (lat == CW'(i + 1)) begin
                    st_d.pend[i] = 1'b1;
                end
            end
            if (lat > CW'(PD)) begin
                st_d.lcnt = lat;
                st_d.hi_m = hi_mark;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_q = st_q.busy;
    assign pend_q = st_q.pend;
    assign res    = st_q.pend[0] | (st_q.lcnt == CW'(1));
    assign hi_res = st_q.hi_p;

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (busy_q > CW'(1)) |=> (busy_q == $past(busy_q) - 1'b1)) else $error("hold broken"); // R8
    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        ld |-> (busy_q <= CW'(1))) else $error("load while held"); // R10
    AST_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        (ld && lat != '0) |-> ((pend_q & (PD'(1) << lat)) == '0)) else $error("result slot clash"); // R11

endmodule

// File: rtl/resv_decode.sv
module resv_decode
    import resv_pkg::*;
#(
    parameter int NU = NUM_UNITS,
    parameter int CW = CNT_W,
    parameter int PD = PIPE_D
) (
    input  logic [3:0]             cls,
    input  logic                   dbl,
    input  logic [NU-1:0][CW-1:0]  busy,
    input  logic [NU-1:0][PD-1:0]  pend,
    output logic                   can_go,
    output logic [NU-1:0]          ld,
    output logic [NU-1:0][CW-1:0]  hold_m1,
    output logic [NU-1:0][CW-1:0]  lat,
    output logic [NU-1:0]          hi_mark
);

    function automatic logic slot_ok(input logic [PD-1:0] p, input int l);
        return (l == 0) || (((p >> l) & PD'(1)) == '0);
    endfunction

    function automatic logic unit_ok(input logic [CW-1:0] b, input logic [PD-1:0] p,
                                     input int l);
        return (b == '0) && slot_ok(p, l);
    endfunction

    int   ua;
    int   ha;
    int   la;
    logic hia;
    logic ok;
    logic a1_ok;
    logic a2_ok;

    always_comb begin
        ld      = '0;
        hold_m1 = '0;
        lat     = '0;
        hi_mark = '0;
        ua      = U_ALU1;
        ha      = 1;
        la      = 1;
        hia     = 1'b0;
        a1_ok   = unit_ok(busy[U_ALU1], pend[U_ALU1], 1);
        a2_ok   = unit_ok(busy[U_ALU2], pend[U_ALU2], 1);
        ok      = 1'b0;
        case (op_cls_e'(cls))
            OP_IALU: begin
                ua = a1_ok ? U_ALU1 : U_ALU2;
                ok = a1_ok | a2_ok;
            end
            OP_ALU1: begin
                ok = a1_ok;
            end
            OP_MTF: begin
                la = 3;
                ok = unit_ok(busy[U_ALU1], pend[U_ALU1], 3);
            end
            OP_MFF, OP_FMUL: begin
                ua = U_FMUL;
                la = 2;
                ok = unit_ok(busy[U_FMUL], pend[U_FMUL], 2);
            end
            OP_IMUL: begin
                ua = U_ALU2;
                ha = dbl ? HOLD_IMUL_D : HOLD_IMUL_S;
                la = ha;
                ok = unit_ok(busy[U_ALU2], pend[U_ALU2], la);
            end
            OP_IDIV: begin
                ua  = U_ALU2;
                ha  = dbl ? HOLD_IDIV_D : HOLD_IDIV_S;
                la  = dbl ? LAT_IDIV_D : LAT_IDIV_S;
                hia = 1'b1;
                ok  = unit_ok(busy[U_ALU2], pend[U_ALU2], la);
            end
            OP_LD, OP_FLD, OP_ST: begin
                ua = U_LSU;
                la = (op_cls_e'(cls) == OP_LD) ? 2 : (op_cls_e'(cls) == OP_FLD) ? 3 : 0;
                ok = unit_ok(busy[U_LSU], pend[U_LSU], la);
            end
            OP_FADD: begin
                ua = U_FADD;
                la = 2;
                ok = unit_ok(busy[U_FADD], pend[U_FADD], 2);
            end
            OP_FCVT: begin
                ua = U_FADD;
                ha = dbl ? 2 : 1;
                la = dbl ? 4 : 2;
                ok = unit_ok(busy[U_FADD], pend[U_FADD], la);
            end
            OP_FMA: begin
                ua = U_FADD;
                la = 0;
                ok = unit_ok(busy[U_FADD], pend[U_FADD], 0)
                     && (busy[U_FMUL] <= CW'(1))
                     && slot_ok(pend[U_FMUL], LAT_FMA);
            end
            OP_FDIV: begin
                ua = U_FDIV;
                ha = dbl ? HOLD_FDIV_D : HOLD_FDIV_S;
                la = dbl ? LAT_FDIV_D : LAT_FDIV_S;
                ok = unit_ok(busy[U_FDIV], pend[U_FDIV], la);
            end
            OP_FSQRT: begin
                ua = U_FSQR;
                ha = dbl ? HOLD_SQRT_D : HOLD_SQRT_S;
                la = dbl ? LAT_SQRT_D : LAT_SQRT_S;
                ok = unit_ok(busy[U_FSQR], pend[U_FSQR], la);
            end
            OP_UNK: begin
                ok = a1_ok && (busy[U_ALU2] == '0);
            end
            default: ok = 1'b0;
        endcase

        can_go = ok;
        if (ok) begin
            ld[ua]      = 1'b1;
            hold_m1[ua] = CW'(ha - 1);
            lat[ua]     = CW'(la);
            hi_mark[ua] = hia;
            if (op_cls_e'(cls) == OP_FMA) begin
                ld[U_FMUL]      = 1'b1;
                hold_m1[U_FMUL] = CW'(1);
                lat[U_FMUL]     = CW'(LAT_FMA);
            end
            if (op_cls_e'(cls) == OP_UNK) begin
                ld[U_ALU2] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/resv_board.sv
module resv_board
    import resv_pkg::*;
#(
    parameter int NU = NUM_UNITS,
    parameter int CW = CNT_W,
    parameter int PD = PIPE_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    output logic          iss_ready,
    input  logic [3:0]    iss_cls,
    input  logic          iss_dbl,
    output logic [NU-1:0] grant,
    output logic [NU-1:0] res_rdy,
    output logic          hi_rdy,
    output logic          fma_fwd
);

    typedef struct packed {
        logic [LAT_FMA_FWD-1:0] fwd;
    } bstate_t;

    bstate_t st_d, st_q;

    logic [NU-1:0][CW-1:0] busy_v;
    logic [NU-1:0][PD-1:0] pend_v;
    logic [NU-1:0]         ld_raw;
    logic [NU-1:0][CW-1:0] hold_v;
    logic [NU-1:0][CW-1:0] lat_v;
    logic [NU-1:0]         him_v;
    logic [NU-1:0]         hires_v;
    logic                  can_go;
    logic                  fire;

    resv_decode #(.NU(NU), .CW(CW), .PD(PD)) u_dec (
        .cls     (iss_cls),
        .dbl     (iss_dbl),
        .busy    (busy_v),
        .pend    (pend_v),
        .can_go  (can_go),
        .ld      (ld_raw),
        .hold_m1 (hold_v),
        .lat     (lat_v),
        .hi_mark (him_v)
    );

    assign fire      = iss_valid & can_go;
    assign iss_ready = can_go;
    assign grant     = ld_raw & {NU{fire}};

    for (genvar u = 0; u < NU; u++) begin : g_unit
        resv_unit #(.CW(CW), .PD(PD)) u_unit (
            .clk     (clk),
            .rst     (rst),
            .ld      (grant[u]),
            .hold_m1 (hold_v[u]),
            .lat     (lat_v[u]),
            .hi_mark (him_v[u]),
            .busy_q  (busy_v[u]),
            .pend_q  (pend_v[u]),
            .res     (res_rdy[u]),
            .hi_res  (hires_v[u])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.fwd = {fire && (op_cls_e'(iss_cls) == OP_FMA), st_q.fwd[LAT_FMA_FWD-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_rdy  = hires_v[U_ALU2];
    assign fma_fwd = st_q.fwd[0];

    AST_ALU1_ONLY: assert property (@(posedge clk) disable iff (rst)
        (fire && (iss_cls == 4'd1 || iss_cls == 4'd2)) |-> (grant == NU'(1 << U_ALU1))) else $error("alu1 route"); // R2
    AST_MULDIV_ALU2: assert property (@(posedge clk) disable iff (rst)
        (fire && (iss_cls == 4'd4 || iss_cls == 4'd5)) |-> (grant == NU'(1 << U_ALU2))) else $error("alu2 route"); // R3
    AST_UNK_BOTH: assert property (@(posedge clk) disable iff (rst)
        (fire && iss_cls == 4'd15) |-> ($countones(grant) == 2 && grant[U_ALU1] && grant[U_ALU2])) else $error("unknown pair"); // R9
    AST_FMA_PAIR: assert property (@(posedge clk) disable iff (rst)
        (fire && iss_cls == 4'd12) |-> (grant[U_FADD] && grant[U_FMUL])) else $error("fma pair"); // R6
    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        hi_rdy |-> $past(res_rdy[U_ALU2])) else $error("hi without lo"); // R4
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> (grant == '0)) else $error("grant without offer"); // R10

endmodule

// File: tb/resv_board_bench.sv
module resv_board_bench;

    localparam int K_HI  = 7;
    localparam int K_FWD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic       iss_ready;
    logic [3:0] iss_cls = '0;
    logic       iss_dbl = 1'b0;
    logic [6:0] grant;
    logic [6:0] res_rdy;
    logic       hi_rdy;
    logic       fma_fwd;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int    kind;
        int    due;
        string rq;
    } exp_t;

    exp_t expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    resv_board u_resv_board (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_ready (iss_ready),
        .iss_cls   (iss_cls),
        .iss_dbl   (iss_dbl),
        .grant     (grant),
        .res_rdy   (res_rdy),
        .hi_rdy    (hi_rdy),
        .fma_fwd   (fma_fwd)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int due, input string rq);
        exp_t e;
        e.kind = kind;
        e.due  = due;
        e.rq   = rq;
        expq.push_back(e);
    endtask

    // ru: result unit (-1 none), rl: its latency, hl/fl: HI and forward latencies (0 none)
    task automatic do_op(input int c, input bit d, input int g, input int w_exp,
                         input int ru, input int rl, input int hl, input int fl,
                         input string rq);
        int w = 0;
        bit done = 0;
        iss_cls   = 4'(c);
        iss_dbl   = d;
        iss_valid = 1'b1;
        while (!done) begin
            #1;
            if (iss_ready) begin
                chk(grant == 7'(g), rq, "grant", int'(grant), g);
                if (w_exp >= 0) chk(w == w_exp, rq, "stall cycles", w, w_exp);
                if (ru >= 0) push(ru, cyc + rl, rq);
                if (hl > 0) push(K_HI, cyc + hl, rq);
                if (fl > 0) push(K_FWD, cyc + fl, rq);
                done = 1;
            end else begin
                if (w == 0) chk(grant == 7'd0, "R10", "grant while held", int'(grant), 0);
                w++;
                if (w > 2000) begin
                    chk(1'b0, rq, "never issued", w, w_exp);
                    done = 1;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        iss_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares result pulses against the expected queue
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            logic [8:0] expv;
            logic [8:0] actv;
            string      rq;
            expv = '0;
            rq   = "R11";
            for (int i = expq.size() - 1; i >= 0; i--) begin
                if (expq[i].due == cyc) begin
                    expv[expq[i].kind] = 1'b1;
                    rq = expq[i].rq;
                    expq.delete(i);
                end
            end
            actv = {fma_fwd, hi_rdy, res_rdy};
            if (expv != '0 || actv != '0) chk(actv == expv, rq, "result flags", int'(actv), int'(expv));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "timeout", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: idle after reset
        #1;
        chk(grant == 7'd0 && res_rdy == 7'd0 && !hi_rdy && !fma_fwd, "R12", "outputs after reset",
            int'({fma_fwd, hi_rdy, res_rdy, grant}), 0);
        iss_cls = 4'd15;
        #1;
        chk(iss_ready, "R12", "unknown ready", int'(iss_ready), 1);
        iss_cls = 4'd5; iss_dbl = 1'b1;
        #1;
        chk(iss_ready, "R12", "divide ready", int'(iss_ready), 1);
        iss_cls = 4'd14;
        #1;
        chk(iss_ready, "R12", "sqrt ready", int'(iss_ready), 1);
        @(negedge clk);

        // R1: plain op prefers ALU1
        do_op(0, 0, 7'h01, 0, 0, 1, 0, 0, "R1");
        idle(4);
        // R2/R5/R1: move-to-FP on ALU1, load, then plain op diverted to ALU2 by slot clash
        do_op(2, 0, 7'h01, 0, 0, 3, 0, 0, "R2");
        do_op(6, 0, 7'h40, 0, 6, 2, 0, 0, "R5");
        do_op(0, 0, 7'h02, 0, 1, 1, 0, 0, "R1");
        idle(4);
        // R11: ALU1-only op waits out the slot clash
        do_op(2, 0, 7'h01, 0, 0, 3, 0, 0, "R2");
        do_op(6, 0, 7'h40, 0, 6, 2, 0, 0, "R5");
        do_op(1, 0, 7'h01, 1, 0, 1, 0, 0, "R11");
        idle(4);
        // R4/R3: single divide then multiply held 34 cycles
        do_op(5, 0, 7'h02, 0, 1, 34, 35, 0, "R4");
        do_op(4, 0, 7'h02, 34, 1, 6, 0, 0, "R3");
        idle(8);
        // R4/R1/R3: double divide, plain op to ALU1, double multiply waits
        do_op(5, 1, 7'h02, 0, 1, 66, 67, 0, "R4");
        do_op(0, 0, 7'h01, 0, 0, 1, 0, 0, "R1");
        do_op(4, 1, 7'h02, 65, 1, 10, 0, 0, "R3");
        idle(12);
        // R9: unknown takes both ALUs, then waits for a held ALU2
        do_op(15, 0, 7'h03, 0, 0, 1, 0, 0, "R9");
        do_op(4, 1, 7'h02, 0, 1, 10, 0, 0, "R3");
        do_op(15, 0, 7'h03, 9, 0, 1, 0, 0, "R9");
        idle(12);
        // R5/R11: load/store stream
        do_op(6, 0, 7'h40, 0, 6, 2, 0, 0, "R5");
        do_op(7, 0, 7'h40, 0, 6, 3, 0, 0, "R5");
        do_op(8, 0, 7'h40, 0, -1, 0, 0, 0, "R5");
        do_op(6, 0, 7'h40, 0, 6, 2, 0, 0, "R5");
        do_op(7, 0, 7'h40, 0, 6, 3, 0, 0, "R5");
        do_op(6, 0, 7'h40, 1, 6, 2, 0, 0, "R11");
        idle(5);
        // R6: two fused ops back to back, then multiply held by hold and slot
        do_op(12, 0, 7'h0C, 0, 3, 4, 0, 2, "R6");
        do_op(12, 0, 7'h0C, 0, 3, 4, 0, 2, "R6");
        do_op(10, 0, 7'h08, 2, 3, 2, 0, 0, "R6");
        idle(6);
        // R7: conversions and add
        do_op(11, 1, 7'h04, 0, 2, 4, 0, 0, "R7");
        do_op(9, 0, 7'h04, 2, 2, 2, 0, 0, "R7");
        do_op(11, 0, 7'h04, 0, 2, 2, 0, 0, "R7");
        do_op(3, 0, 7'h08, 0, 3, 2, 0, 0, "R3");
        idle(5);
        // R8: divider and square root in parallel with the multiplier
        do_op(13, 0, 7'h10, 0, 4, 12, 0, 0, "R8");
        do_op(14, 1, 7'h20, 0, 5, 33, 0, 0, "R8");
        do_op(10, 0, 7'h08, 0, 3, 2, 0, 0, "R8");
        do_op(13, 1, 7'h10, 11, 4, 19, 0, 0, "R8");
        do_op(14, 0, 7'h20, 21, 5, 18, 0, 0, "R8");
        idle(80);
        chk(expq.size() == 0, "R11", "results left pending", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule